// File: doc/BRIEF.md
# Cascaded mappable interrupt controller

This block gathers level-sensitive interrupt lines into two CPU request outputs. Two local groups of eight lines each have their own live status and a software mask. A request is raised when any line is both active and enabled. A third set of eight mappable lines shares one status view and is gated by two independent mask registers. Each gated result collapses to a single bit, which is injected into a fixed bit of one local group: the first map mask feeds bit 7 of local group 0, and the second feeds bit 3 of local group 1. The local mask still applies to that injected bit. Software therefore sees a fixed numbering: local group 0 is 0–7, local group 1 is 8–15, mappable lines under the first mask are 16–23, and mappable lines under the second mask are 24–31.

Two timer events are captured in set-on-pulse latches, because the events are single-cycle pulses rather than levels. Latch k appears in bit k of local group 1 status. Software clears a latch by writing a 1 to its bit in the timer-clear register. Access is through a simple word-aligned register port: reads are combinational and zero-extended to 32 bits, and writes use only the low 8 data bits.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: `irq_lo` equals the OR of (local0 status AND local0 mask), registered, so an input or mask change reaches `irq_lo` exactly one clock edge later.
- R2: `irq_hi` equals the OR of (local1 status AND local1 mask) with the same one-edge latency, independent of local group 0.
- R3: When (map status AND map mask 0) is nonzero, local0 status bit 7 reads as 1 at offset 0x00, and it raises `irq_lo` only if local0 mask bit 7 is set.
- R4: When (map status AND map mask 1) is nonzero, local1 status bit 3 reads as 1 at offset 0x08, and it raises `irq_hi` only if local1 mask bit 3 is set; map mask 1 has no effect on local group 0.
- R5: A local mask of zero keeps that group's request low whatever its inputs, cascade or timer bits are.
- R6: A one-cycle pulse on `tmr_evt[k]` (k = 0,1) sets timer latch k, which ORs into local1 status bit k and reads at offset 0x1C bit k. Writing offset 0x1C clears each latch whose data bit is 1 and leaves the others set. A pulse in the same cycle as a clear keeps the latch set.
- R7: After reset, all four masks read 0, both timer latches read 0, and both request outputs are low.
- R8: The register map is as follows. Status registers are read-only, and writes to them change nothing: local0 status at 0x00, local1 status at 0x08, and map status at 0x10 (live `map_in`). The masks are at 0x04 (local0), 0x0C (local1), 0x14 (map mask 0) and 0x18 (map mask 1). Timer latches and clear are at 0x1C. Reads are zero-extended, writes use data bits 7:0, and offsets 0x20 and above read 0.
- R9: Each mask register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc0_in | input | 8 | Level interrupt lines of local group 0 |
| loc1_in | input | 8 | Level interrupt lines of local group 1 |
| map_in | input | 8 | Mappable level interrupt lines |
| tmr_evt | input | 2 | Timer event pulses, one per latch |
| reg_addr | input | 6 | Byte address of the register port |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, bits 7:0 used |
| reg_rdata | output | 32 | Combinational read data |
| irq_lo | output | 1 | Request from local group 0 |
| irq_hi | output | 1 | Request from local group 1 |

## Verification
Local inputs are driven both with patterns that avoid the mask and with patterns that overlap it. Checking the request in the cycle of the change and in the cycle after separates a correct mask from a missing one and pins the one-edge latency. Mappable lines are driven under only one map mask at a time, which shows the two cascades land in different groups and bits, and whether the local mask still gates them. Timer pulses are combined with partial clears and with a clear in the same cycle, which shows per-bit clearing and that set wins over clear.

// File: rtl/cic_pkg.sv
// Shared register word indices for the cascaded interrupt controller.
// Assumes byte addresses with the two low bits ignored.
package cic_pkg;
    localparam int unsigned IDX_L0_STAT = 0;
    localparam int unsigned IDX_L0_MASK = 1;
    localparam int unsigned IDX_L1_STAT = 2;
    localparam int unsigned IDX_L1_MASK = 3;
    localparam int unsigned IDX_MP_STAT = 4;
    localparam int unsigned IDX_MP_MSK0 = 5;
    localparam int unsigned IDX_MP_MSK1 = 6;
    localparam int unsigned IDX_TMR     = 7;
endpackage

// File: rtl/cic_group.sv
// One local interrupt group: live status (inputs OR injected bits),
// a writable mask and a registered request. Assumes level inputs
// already synchronous to clk.
module cic_group #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    input  logic [N-1:0] inject,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         req
);
    // Combine live lines with cascade and latch bits.
    always_comb status = raw_in | inject;

    // Mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Registered request: any enabled active bit.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= |(status & mask);
    end
endmodule

// File: rtl/cic_map.sv
// Mappable section: one shared status view gated by NMASK independent
// masks, each reduced to one cascade bit. Assumes level inputs.
module cic_map #(
    parameter int unsigned N     = 8,
    parameter int unsigned NMASK = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              map_in,
    input  logic [NMASK-1:0]          mask_we,
    input  logic [N-1:0]              mask_wdata,
    output logic [NMASK-1:0][N-1:0]   mask,
    output logic [NMASK-1:0]          hit
);
    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        // Map mask register g, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)          mask[g] <= '0;
            else if (mask_we[g]) mask[g] <= mask_wdata;
        end
        // Reduce gated map status to one cascade bit.
        always_comb hit[g] = |(map_in & mask[g]);
    end
endmodule

// File: rtl/cic_tmr_latch.sv
// Set-on-pulse timer event latches with per-bit write-one-to-clear.
// A pulse in the same cycle as a clear wins, so no event is lost.
module cic_tmr_latch #(
    parameter int unsigned NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] pulse,
    input  logic          clr_we,
    input  logic [NT-1:0] clr_bits,
    output logic [NT-1:0] latch
);
    logic [NT-1:0] clr_mask;

    // Clear only on a write strobe.
    always_comb clr_mask = clr_we ? clr_bits : '0;

    // Latch update: clear selected bits, then set pulsed bits.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= '0;
        else        latch <= (latch & ~clr_mask) | pulse;
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Top of the cascaded mappable interrupt controller. Decodes a word
// aligned register port, cascades the two map results into fixed local
// bits and feeds the timer latches into local group 1 low bits.
// Assumes GRP_W <= DATA_W and NTMR <= GRP_W.
module cascade_irq_ctrl
    import cic_pkg::*;
#(
    parameter int unsigned GRP_W     = 8,
    parameter int unsigned NTMR      = 2,
    parameter int unsigned CASC0_BIT = 7,
    parameter int unsigned CASC1_BIT = 3,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  loc0_in,
    input  logic [GRP_W-1:0]  loc1_in,
    input  logic [GRP_W-1:0]  map_in,
    input  logic [NTMR-1:0]   tmr_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam int unsigned NMAP   = 2;

    logic [WIDX_W-1:0]           widx;
    logic [GRP_W-1:0]            wbyte;
    logic                        unused_bits;
    logic [GRP_W-1:0]            stat0, stat1, mask0, mask1;
    logic [GRP_W-1:0]            inj0, inj1;
    logic [NMAP-1:0][GRP_W-1:0]  mmask;
    logic [NMAP-1:0]             mhit;
    logic [NMAP-1:0]             mwe;
    logic [NTMR-1:0]             tlatch;
    logic                        we_l0, we_l1, we_tmr;

    // Address and data slicing.
    always_comb begin
        widx        = reg_addr[ADDR_W-1:2];
        wbyte       = reg_wdata[GRP_W-1:0];
        unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:GRP_W]};
    end

    // Write strobe decode per register.
    always_comb begin
        we_l0  = reg_we && (widx == WIDX_W'(IDX_L0_MASK));
        we_l1  = reg_we && (widx == WIDX_W'(IDX_L1_MASK));
        mwe[0] = reg_we && (widx == WIDX_W'(IDX_MP_MSK0));
        mwe[1] = reg_we && (widx == WIDX_W'(IDX_MP_MSK1));
        we_tmr = reg_we && (widx == WIDX_W'(IDX_TMR));
    end

    // Cascade and timer injection into the local groups.
    always_comb begin
        inj0 = '0;
        inj1 = '0;
        inj0[CASC0_BIT] = mhit[0];
        inj1[CASC1_BIT] = mhit[1];
        for (int k = 0; k < NTMR; k++) inj1[k] = inj1[k] | tlatch[k];
    end

    cic_map #(.N(GRP_W), .NMASK(NMAP)) u_map (
        .clk(clk), .rst_n(rst_n), .map_in(map_in), .mask_we(mwe),
        .mask_wdata(wbyte), .mask(mmask), .hit(mhit)
    );

    cic_tmr_latch #(.NT(NTMR)) u_tmr (
        .clk(clk), .rst_n(rst_n), .pulse(tmr_evt), .clr_we(we_tmr),
        .clr_bits(wbyte[NTMR-1:0]), .latch(tlatch)
    );

    cic_group #(.N(GRP_W)) u_grp0 (
        .clk(clk), .rst_n(rst_n), .raw_in(loc0_in), .inject(inj0),
        .mask_we(we_l0), .mask_wdata(wbyte), .status(stat0),
        .mask(mask0), .req(irq_lo)
    );

    cic_group #(.N(GRP_W)) u_grp1 (
        .clk(clk), .rst_n(rst_n), .raw_in(loc1_in), .inject(inj1),
        .mask_we(we_l1), .mask_wdata(wbyte), .status(stat1),
        .mask(mask1), .req(irq_hi)
    );

    // Read mux, zero-extended; unmapped words read zero.
    always_comb begin
        reg_rdata = '0;
        case (widx)
            WIDX_W'(IDX_L0_STAT): reg_rdata = DATA_W'(stat0);
            WIDX_W'(IDX_L0_MASK): reg_rdata = DATA_W'(mask0);
            WIDX_W'(IDX_L1_STAT): reg_rdata = DATA_W'(stat1);
            WIDX_W'(IDX_L1_MASK): reg_rdata = DATA_W'(mask1);
            WIDX_W'(IDX_MP_STAT): reg_rdata = DATA_W'(map_in);
            WIDX_W'(IDX_MP_MSK0): reg_rdata = DATA_W'(mmask[0]);
            WIDX_W'(IDX_MP_MSK1): reg_rdata = DATA_W'(mmask[1]);
            WIDX_W'(IDX_TMR):     reg_rdata = DATA_W'(tlatch);
            default:              reg_rdata = '0;
        endcase
    end

    // Request latency for group 0.
    p_irq_lo_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_lo == $past(|(loc0_in & mask0) | (mhit[0] & mask0[CASC0_BIT]))));

    // Request latency for group 1.
    p_irq_hi_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_hi == $past(|(stat1 & mask1))));

    // Map mask 0 cascade reaches local0 status bit.
    p_cascade_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(map_in & mmask[0])) |-> stat0[CASC0_BIT]);

    // Map mask 1 cascade reaches local1 status bit.
    p_cascade_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(map_in & mmask[1])) |-> stat1[CASC1_BIT]);

    // Zero mask silences the group.
    p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask0) == '0) |-> !irq_lo);

    // Timer pulse always sets its latch.
    p_tmr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |$past(tmr_evt)) |-> ((tlatch & $past(tmr_evt)) == $past(tmr_evt)));
endmodule

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  loc0_in, loc1_in, map_in;
    logic [1:0]  tmr_evt;
    logic [5:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_L0S = 6'h00, A_L0M = 6'h04, A_L1S = 6'h08,
                           A_L1M = 6'h0C, A_MPS = 6'h10, A_MM0 = 6'h14,
                           A_MM1 = 6'h18, A_TMR = 6'h1C, A_BAD = 6'h24;

    cascade_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .loc0_in(loc0_in), .loc1_in(loc1_in),
        .map_in(map_in), .tmr_evt(tmr_evt), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        check("R7 irq_lo", {31'b0, irq_lo}, 0);
        check("R7 irq_hi", {31'b0, irq_hi}, 0);
        rd_chk("R7 mask0", A_L0M, 0);
        rd_chk("R7 mask1", A_L1M, 0);
        rd_chk("R7 mmask0", A_MM0, 0);
        rd_chk("R7 mmask1", A_MM1, 0);
        rd_chk("R7 timer", A_TMR, 0);
    endtask

    task automatic t_regs;
        wr(A_L0M, 32'hA5A5_A53C);
        rd_chk("R9 mask0 readback", A_L0M, 32'h3C);
        wr(A_MM1, 32'h0000_0181);
        rd_chk("R9 mmask1 readback", A_MM1, 32'h81);
        wr(A_L0S, 32'hFF);
        rd_chk("R8 status read-only", A_L0S, 0);
        map_in = 8'h5A;
        rd_chk("R8 map status live", A_MPS, 32'h5A);
        rd_chk("R8 unmapped", A_BAD, 0);
        map_in = 8'h00;
        wr(A_L0M, 0);
        wr(A_MM1, 0);
    endtask

    task automatic t_local;
        wr(A_L0M, 32'h01);
        @(negedge clk); loc0_in = 8'h02;
        @(negedge clk); #1;
        check("R1 unmasked line", {31'b0, irq_lo}, 0);
        loc0_in = 8'h03; #1;
        check("R1 before edge", {31'b0, irq_lo}, 0);
        @(negedge clk); #1;
        check("R1 after one edge", {31'b0, irq_lo}, 1);
        check("R2 group1 untouched", {31'b0, irq_hi}, 0);
        wr(A_L0M, 0);
        @(negedge clk); #1;
        check("R5 zero mask0", {31'b0, irq_lo}, 0);
        loc0_in = 8'h00;
        wr(A_L1M, 32'h80);
        loc1_in = 8'h80;
        @(negedge clk); #1;
        check("R2 group1 request", {31'b0, irq_hi}, 1);
        check("R2 group0 quiet", {31'b0, irq_lo}, 0);
        loc1_in = 8'h00;
        @(negedge clk); #1;
        check("R2 group1 release", {31'b0, irq_hi}, 0);
        wr(A_L1M, 0);
    endtask

    task automatic t_cascade0;
        wr(A_MM0, 32'h10);
        map_in = 8'h20; #1;
        rd_chk("R3 no hit status", A_L0S, 0);
        map_in = 8'h10; #1;
        rd_chk("R3 hit sets bit7", A_L0S, 32'h80);
        @(negedge clk); #1;
        check("R3 gated by mask0 bit7", {31'b0, irq_lo}, 0);
        wr(A_L0M, 32'h80);
        @(negedge clk); #1;
        check("R3 cascade request", {31'b0, irq_lo}, 1);
        check("R3 no leak to group1", {31'b0, irq_hi}, 0);
        rd_chk("R4 group1 status clear", A_L1S, 0);
        map_in = 8'h00;
        wr(A_MM0, 0);
    endtask

    task automatic t_cascade1;
        wr(A_MM1, 32'h04);
        wr(A_L1M, 32'h08);
        map_in = 8'h04;
        rd_chk("R4 hit sets bit3", A_L1S, 32'h08);
        rd_chk("R4 group0 status clear", A_L0S, 0);
        @(negedge clk); #1;
        check("R4 cascade request", {31'b0, irq_hi}, 1);
        check("R4 group0 untouched", {31'b0, irq_lo}, 0);
        wr(A_L1M, 32'hF7);
        @(negedge clk); #1;
        check("R4 gated by mask1 bit3", {31'b0, irq_hi}, 0);
        wr(A_L1M, 0);
        loc1_in = 8'hFF;
        @(negedge clk); #1;
        check("R5 zero mask1", {31'b0, irq_hi}, 0);
        loc1_in = 8'h00; map_in = 8'h00;
        wr(A_MM1, 0);
        wr(A_L0M, 0);
    endtask

    task automatic t_timer;
        @(negedge clk); tmr_evt = 2'b10;
        @(negedge clk); tmr_evt = 2'b00;
        rd_chk("R6 latch1 set", A_TMR, 32'h2);
        rd_chk("R6 status bit1", A_L1S, 32'h2);
        wr(A_L1M, 32'h02);
        @(negedge clk); #1;
        check("R6 timer request", {31'b0, irq_hi}, 1);
        wr(A_TMR, 32'h01);
        rd_chk("R6 other bit kept", A_TMR, 32'h2);
        wr(A_TMR, 32'h03);
        rd_chk("R6 cleared", A_TMR, 0);
        @(negedge clk); #1;
        check("R6 request released", {31'b0, irq_hi}, 0);
        @(negedge clk);
        tmr_evt = 2'b01; reg_addr = A_TMR; reg_wdata = 32'h03; reg_we = 1'b1;
        @(negedge clk);
        tmr_evt = 2'b00; reg_we = 1'b0;
        rd_chk("R6 set wins over clear", A_TMR, 32'h1);
        wr(A_TMR, 32'h03);
        rd_chk("R6 clear after race", A_TMR, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: all requirements, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; loc0_in = 0; loc1_in = 0; map_in = 0; tmr_evt = 0;
        reg_addr = 0; reg_we = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_local();
        t_cascade0();
        t_cascade1();
        t_timer();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule